// File: doc/BRIEF.md
# Masked Event Interrupt and Wakeup Unit

This block gathers three single-cycle event strobes from a timer (compare hit, counter wrap and input capture) into a small sticky status register. An event is recorded only when its interrupt-enable bit is set. A level interrupt line is high whenever any recorded bit is present. A second, independent mask sends the same strobes to a one-cycle wakeup pulse. This pulse does not depend on the interrupt mask.

Software reaches the block through a simple 32-bit register port with write strobe, word address and combinational read data. It clears status bits by writing ones to them. Clearing the capture bit also sends a one-cycle restart pulse to the external capture sequencer. A configuration register holds a masked set of option bits. Writing its reset bit clears every register in the block and sends a soft-reset pulse to the rest of the timer. A health register always shows that reset has completed.

Top module: `evt_irq_unit`

## Requirements
- R1: Status bit 0 records a compare hit, bit 1 a counter wrap and bit 2 a capture. An event sets its bit on the next clock edge only when the bit with the same index in the interrupt-enable register (offset 0x04) is 1.
- R2: `irq_o` is high exactly while at least one status bit (offset 0x00) is 1. It falls in the cycle after the last set bit is cleared.
- R3: A write to offset 0x00 clears each status bit whose data bit is 1 and leaves bits written with 0 unchanged.
- R4: A write to offset 0x00 with data bit 2 set drives `cap_clr_o` high for exactly the following cycle. Otherwise `cap_clr_o` stays low.
- R5: When an event arrives and the matching wakeup-enable bit (offset 0x08) is 1, `wake_o` is high in the following cycle, whatever the interrupt-enable setting.
- R6: If an enabled event and a write-one clear of the same status bit happen in the same cycle, the bit ends up set.
- R7: The interrupt-enable and wakeup-enable registers store only data bits 2:0. Their upper bits read as 0.
- R8: The configuration register (offset 0x0C) stores only the data bits under mask 0x33D.
- R9: A write to offset 0x0C with data bit 1 set clears status, both enables, configuration and any pending pulse. `srst_o` is then high for exactly the following cycle.
- R10: The health register (offset 0x10) always reads 1, and writes to it change nothing. Unmapped offsets read 0.
- R11: After `rst_n` is released, every register reads 0 except health, and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_match_i | input | 1 | Compare-hit strobe |
| ev_ovf_i | input | 1 | Counter-wrap strobe |
| ev_cap_i | input | 1 | Capture strobe |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` |
| irq_o | output | 1 | Level interrupt |
| wake_o | output | 1 | Wakeup pulse |
| cap_clr_o | output | 1 | Capture-sequencer restart pulse |
| srst_o | output | 1 | Soft-reset pulse to the timer |

## Verification
Directed sequences cover several cases. Each event is fired with only one enable set, which separates the three bit positions. A clear with zero data is issued while bits are set, and wakeup is exercised with the interrupt mask off, which shows that the two masks are independent. Same-cycle set and clear of one bit checks the priority. Seeded random mixes of events, clears, enable writes and occasional soft resets then run against a bench model, with the status register and all four outputs compared after every cycle.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
   localparam int unsigned EV_MATCH = 0;
   localparam int unsigned EV_OVF   = 1;
   localparam int unsigned EV_CAP   = 2;
   localparam int unsigned EV_COUNT = 3;

   typedef enum logic [2:0] {
      SEL_STAT,
      SEL_IEN,
      SEL_WEN,
      SEL_CFG,
      SEL_HLTH,
      SEL_NONE
   } reg_sel_e;
endpackage

// File: rtl/evt_status_bank.sv
module evt_status_bank #(
   parameter int unsigned NEV      = 3,
   parameter bit          SET_WINS = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           soft_clr,
   input  logic [NEV-1:0] ev,
   input  logic [NEV-1:0] ien,
   input  logic [NEV-1:0] clr,
   output logic [NEV-1:0] stat_q
);
   for (genvar i = 0; i < NEV; i++) begin : g_bit
      logic set_i;
      logic nxt_i;
      assign set_i = ev[i] & ien[i];

      if (SET_WINS) begin : g_set_pri
         assign nxt_i = set_i | (stat_q[i] & ~clr[i]);
      end else begin : g_clr_pri
         assign nxt_i = ~clr[i] & (set_i | stat_q[i]);
      end

      always_ff @(posedge clk) begin
         if (!rst_n || soft_clr) stat_q[i] <= 1'b0;
         else                    stat_q[i] <= nxt_i;
      end

      // R1: a bit cannot appear without an enabled event
      a_r1_set_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
         (!stat_q[i] && !(ev[i] && ien[i])) |=> !stat_q[i]);
      // R6: an enabled event always lands, even against a clear
      if (SET_WINS) begin : g_chk_pri
         a_r6_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (ev[i] && ien[i] && !soft_clr) |=> stat_q[i]);
      end
      // R3: write-one clears when no event competes
      a_r3_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
         (clr[i] && !(ev[i] && ien[i])) |=> !stat_q[i]);
   end
endmodule

// File: rtl/evt_wake_gen.sv
module evt_wake_gen #(
   parameter int unsigned NEV = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           soft_clr,
   input  logic [NEV-1:0] ev,
   input  logic [NEV-1:0] wen,
   output logic           wake_q
);
   logic hit;
   assign hit = |(ev & wen);

   always_ff @(posedge clk) begin
      if (!rst_n || soft_clr) wake_q <= 1'b0;
      else                    wake_q <= hit;
   end

   // R5: a masked-in event yields a pulse on the next cycle
   a_r5_wake_follows_event: assert property (@(posedge clk) disable iff (!rst_n)
      ((|(ev & wen)) && !soft_clr) |=> wake_q);
   // R5: no pulse without a masked-in event one cycle earlier
   a_r5_wake_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
      wake_q |-> $past(|(ev & wen)));
endmodule

// File: rtl/evt_regs.sv
module evt_regs
   import evt_irq_pkg::*;
#(
   parameter int unsigned DW        = 32,
   parameter int unsigned AW        = 8,
   parameter int unsigned NEV       = 3,
   parameter logic [31:0] CFG_MASK  = 32'h0000_033D,
   parameter int unsigned SRST_BIT  = 1,
   parameter logic [7:0]  OFF_STAT  = 8'h00,
   parameter logic [7:0]  OFF_IEN   = 8'h04,
   parameter logic [7:0]  OFF_WEN   = 8'h08,
   parameter logic [7:0]  OFF_CFG   = 8'h0C,
   parameter logic [7:0]  OFF_HLTH  = 8'h10
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           we,
   input  logic [AW-1:0]  addr,
   input  logic [DW-1:0]  wdata,
   input  logic [NEV-1:0] stat,
   output logic [DW-1:0]  rdata,
   output logic [NEV-1:0] ien_q,
   output logic [NEV-1:0] wen_q,
   output logic [NEV-1:0] clr,
   output logic           soft_clr,
   output logic           cap_clr_q,
   output logic           srst_q
);
   localparam logic [DW-1:0] CFG_KEEP = DW'(CFG_MASK);
   localparam int unsigned   PADW     = DW - NEV;

   if (DW < 10 || DW < NEV) begin : g_bad_dw
      $error("evt_regs: data width too small for configuration field");
   end
   if (SRST_BIT >= DW || CFG_MASK[SRST_BIT]) begin : g_bad_srst
      $error("evt_regs: soft reset bit must be outside the stored mask");
   end

   reg_sel_e        sel;
   logic [DW-1:0]   cfg_q;

   always_comb begin
      if      (addr == AW'(OFF_STAT)) sel = SEL_STAT;
      else if (addr == AW'(OFF_IEN))  sel = SEL_IEN;
      else if (addr == AW'(OFF_WEN))  sel = SEL_WEN;
      else if (addr == AW'(OFF_CFG))  sel = SEL_CFG;
      else if (addr == AW'(OFF_HLTH)) sel = SEL_HLTH;
      else                            sel = SEL_NONE;
   end

   assign soft_clr = we && (sel == SEL_CFG) && wdata[SRST_BIT];
   assign clr      = (we && sel == SEL_STAT) ? wdata[NEV-1:0] : '0;

   always_ff @(posedge clk) begin
      if (!rst_n || soft_clr) begin
         ien_q     <= '0;
         wen_q     <= '0;
         cfg_q     <= '0;
         cap_clr_q <= 1'b0;
      end else begin
         if (we && sel == SEL_IEN) ien_q <= wdata[NEV-1:0];
         if (we && sel == SEL_WEN) wen_q <= wdata[NEV-1:0];
         if (we && sel == SEL_CFG) cfg_q <= wdata & CFG_KEEP;
         cap_clr_q <= clr[EV_CAP];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) srst_q <= 1'b0;
      else        srst_q <= soft_clr;
   end

   always_comb begin
      unique case (sel)
         SEL_STAT: rdata = {{PADW{1'b0}}, stat};
         SEL_IEN:  rdata = {{PADW{1'b0}}, ien_q};
         SEL_WEN:  rdata = {{PADW{1'b0}}, wen_q};
         SEL_CFG:  rdata = cfg_q;
         SEL_HLTH: rdata = DW'(1);
         default:  rdata = '0;
      endcase
   end

   // R4: restart pulse only after a capture-bit clear
   a_r4_cap_clr_cause: assert property (@(posedge clk) disable iff (!rst_n)
      cap_clr_q |-> $past(we && addr == AW'(OFF_STAT) && wdata[EV_CAP]));
   // R4: pulse lasts a single cycle without a repeat write
   a_r4_cap_clr_single: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_clr_q && !clr[EV_CAP]) |=> !cap_clr_q);
   // R9: after soft reset the enables are empty
   a_r9_srst_clears: assert property (@(posedge clk) disable iff (!rst_n)
      srst_q |-> (ien_q == '0 && wen_q == '0 && cfg_q == '0));
   // R8: stored configuration never holds bits outside the mask
   a_r8_cfg_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q & ~CFG_KEEP) == '0);
endmodule

// File: rtl/evt_irq_unit.sv
module evt_irq_unit
   import evt_irq_pkg::*;
#(
   parameter int unsigned DW       = 32,
   parameter int unsigned AW       = 8,
   parameter logic [31:0] CFG_MASK = 32'h0000_033D,
   parameter bit          SET_WINS = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ev_match_i,
   input  logic          ev_ovf_i,
   input  logic          ev_cap_i,
   input  logic          reg_we_i,
   input  logic [AW-1:0] reg_addr_i,
   input  logic [DW-1:0] reg_wdata_i,
   output logic [DW-1:0] reg_rdata_o,
   output logic          irq_o,
   output logic          wake_o,
   output logic          cap_clr_o,
   output logic          srst_o
);
   localparam int unsigned NEV = EV_COUNT;

   if (AW < 5) begin : g_bad_aw
      $error("evt_irq_unit: address width cannot reach all offsets");
   end

   logic [NEV-1:0] ev, ien, wen, clr, stat;
   logic           soft_clr;

   always_comb begin
      ev           = '0;
      ev[EV_MATCH] = ev_match_i;
      ev[EV_OVF]   = ev_ovf_i;
      ev[EV_CAP]   = ev_cap_i;
   end

   evt_regs #(
      .DW(DW), .AW(AW), .NEV(NEV), .CFG_MASK(CFG_MASK)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we_i), .addr(reg_addr_i),
      .wdata(reg_wdata_i), .stat(stat), .rdata(reg_rdata_o),
      .ien_q(ien), .wen_q(wen), .clr(clr), .soft_clr(soft_clr),
      .cap_clr_q(cap_clr_o), .srst_q(srst_o)
   );

   evt_status_bank #(.NEV(NEV), .SET_WINS(SET_WINS)) u_stat (
      .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .ev(ev),
      .ien(ien), .clr(clr), .stat_q(stat)
   );

   evt_wake_gen #(.NEV(NEV)) u_wake (
      .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .ev(ev),
      .wen(wen), .wake_q(wake_o)
   );

   assign irq_o = |stat;

   // R2: the line only drops after a register write
   a_r2_irq_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_o) |-> $past(reg_we_i));
   // R2: the line rises only after an event
   a_r2_irq_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> $past(ev_match_i || ev_ovf_i || ev_cap_i));
endmodule

// File: tb/evt_irq_unit_test.sv
module evt_irq_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ev_m = 1'b0, ev_o = 1'b0, ev_c = 1'b0;
   logic        we = 1'b0;
   logic [7:0]  addr = 8'h00;
   logic [31:0] wd = '0;
   logic [31:0] rd;
   logic        irq, wake, capclr, srst;

   int errs = 0;
   int checks = 0;

   logic [2:0]  m_stat = '0, m_ien = '0, m_wen = '0;
   logic [31:0] m_cfg = '0;
   logic        e_wake = 1'b0, e_cap = 1'b0, e_srst = 1'b0;

   always #5 clk = ~clk;

   evt_irq_unit uut (
      .clk(clk), .rst_n(rst_n), .ev_match_i(ev_m), .ev_ovf_i(ev_o),
      .ev_cap_i(ev_c), .reg_we_i(we), .reg_addr_i(addr),
      .reg_wdata_i(wd), .reg_rdata_o(rd), .irq_o(irq), .wake_o(wake),
      .cap_clr_o(capclr), .srst_o(srst)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] model_rd(input logic [7:0] a);
      case (a)
         8'h00:   return {29'd0, m_stat};
         8'h04:   return {29'd0, m_ien};
         8'h08:   return {29'd0, m_wen};
         8'h0C:   return m_cfg;
         8'h10:   return 32'd1;
         default: return 32'd0;
      endcase
   endfunction

   task automatic rdchk(input logic [7:0] a, input string req);
      we = 1'b0; addr = a; #1;
      chk(req, rd, model_rd(a));
   endtask

   task automatic step(input logic [2:0] ev, input logic w, input logic [7:0] a,
                       input logic [31:0] d, input string req);
      logic [2:0]  n_stat, n_ien, n_wen, clrv;
      logic [31:0] n_cfg;
      logic        n_wake, n_cap, n_srst;
      ev_m = ev[0]; ev_o = ev[1]; ev_c = ev[2];
      we = w; addr = a; wd = d;
      n_srst = w && a == 8'h0C && d[1];
      if (n_srst) begin
         n_stat = '0; n_ien = '0; n_wen = '0; n_cfg = '0; n_wake = 0; n_cap = 0;
      end else begin
         clrv   = (w && a == 8'h00) ? d[2:0] : 3'b000;
         n_stat = (m_stat & ~clrv) | (ev & m_ien);
         n_wake = |(ev & m_wen);
         n_cap  = clrv[2];
         n_ien  = (w && a == 8'h04) ? d[2:0] : m_ien;
         n_wen  = (w && a == 8'h08) ? d[2:0] : m_wen;
         n_cfg  = (w && a == 8'h0C) ? (d & 32'h33D) : m_cfg;
      end
      @(posedge clk); #1;
      m_stat = n_stat; m_ien = n_ien; m_wen = n_wen; m_cfg = n_cfg;
      e_wake = n_wake; e_cap = n_cap; e_srst = n_srst;
      ev_m = 0; ev_o = 0; ev_c = 0; we = 0;
      chk({req, " R2 irq"}, {31'd0, irq}, {31'd0, |m_stat});
      chk({req, " R5 wake"}, {31'd0, wake}, {31'd0, e_wake});
      chk({req, " R4 cap_clr"}, {31'd0, capclr}, {31'd0, e_cap});
      chk({req, " R9 srst"}, {31'd0, srst}, {31'd0, e_srst});
      rdchk(8'h00, {req, " R1 status"});
   endtask

   initial begin
      #2_000_000;
      errs++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      int seed;
      seed = $urandom(32'h5EED_0011);
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
      // R11 reset state
      chk("R11 irq", {31'd0, irq}, 0);
      chk("R11 wake", {31'd0, wake}, 0);
      rdchk(8'h00, "R11 stat");
      rdchk(8'h04, "R11 ien");
      rdchk(8'h0C, "R11 cfg");
      rdchk(8'h10, "R10 health");
      rdchk(8'h20, "R10 unmapped");

      // R1: only match enabled; all events fire -> bit 0 only
      step(3'b000, 1, 8'h04, 32'h1, "R1 en match");
      step(3'b111, 0, 8'h00, 0, "R1 match only");
      chk("R1 match bit0", {29'd0, m_stat}, 32'h1);
      step(3'b000, 1, 8'h04, 32'h2, "R1 en ovf");
      step(3'b111, 0, 8'h00, 0, "R1 ovf");
      step(3'b000, 1, 8'h04, 32'h4, "R1 en cap");
      step(3'b011, 0, 8'h00, 0, "R1 cap off");
      step(3'b100, 0, 8'h00, 0, "R1 cap on");
      // R3 clear with zero then ones
      step(3'b000, 1, 8'h00, 32'h0, "R3 zero clear");
      step(3'b000, 1, 8'h00, 32'h2, "R3 clear ovf");
      step(3'b000, 1, 8'h00, 32'h5, "R3 R4 clear rest");
      chk("R2 irq low", {31'd0, irq}, 0);
      // R6 same-cycle set and clear
      step(3'b000, 1, 8'h04, 32'h7, "R6 en all");
      step(3'b001, 0, 8'h00, 0, "R6 prep");
      step(3'b001, 1, 8'h00, 32'h1, "R6 set wins");
      chk("R6 bit held", {31'd0, m_stat[0]}, 1);
      // R5 wake with interrupt mask off
      step(3'b000, 1, 8'h04, 32'h0, "R5 ien off");
      step(3'b000, 1, 8'h08, 32'h2, "R5 wen ovf");
      step(3'b010, 0, 8'h00, 0, "R5 wake");
      step(3'b000, 0, 8'h00, 0, "R5 pulse ends");
      // R7 / R8 / R10 masking
      step(3'b000, 1, 8'h04, 32'hFFFF_FFF8, "R7 ien upper");
      rdchk(8'h04, "R7 ien readback");
      step(3'b000, 1, 8'h08, 32'hFFFF_FFFF, "R7 wen all");
      rdchk(8'h08, "R7 wen readback");
      step(3'b000, 1, 8'h0C, 32'hFFFF_FFFD, "R8 cfg");
      rdchk(8'h0C, "R8 cfg readback");
      step(3'b000, 1, 8'h10, 32'h0, "R10 health write");
      rdchk(8'h10, "R10 health still 1");
      // R9 soft reset while events arrive
      step(3'b000, 1, 8'h04, 32'h7, "R9 prep");
      step(3'b111, 0, 8'h00, 0, "R9 prep ev");
      step(3'b111, 1, 8'h0C, 32'h2, "R9 soft reset");
      rdchk(8'h04, "R9 ien cleared");
      rdchk(8'h0C, "R9 cfg cleared");
      step(3'b000, 0, 8'h00, 0, "R9 pulse ends");

      // random mix
      for (int i = 0; i < 400; i++) begin
         logic [2:0]  ev;
         logic [7:0]  a;
         logic [31:0] d;
         int          k;
         ev = 3'($urandom);
         k  = $urandom_range(0, 19);
         d  = $urandom;
         case (k)
            0, 1, 2, 3, 4: a = 8'h00;
            5, 6:          a = 8'h04;
            7, 8:          a = 8'h08;
            9:             a = 8'h0C;
            default:       a = 8'h00;
         endcase
         if (a == 8'h0C && $urandom_range(0, 3) != 0) d[1] = 1'b0;
         step(ev, k < 10, a, d, "R1 R3 R6 random");
      end

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule